// File: doc/BRIEF.md
# Output Power-Good and Thermal Supervisor

This block watches a converter output that has already been digitized. A 5-bit voltage-select code sets the target output level. The block holds a tolerance window around that level and drives a power-good flag. The flag is high while the sampled feedback voltage sits inside the window. The block also raises a shutdown request when the die gets too hot. That request stays up until the die has cooled well below the trip point.

The voltage-select pins pass through a synchronizer and a stability filter, so a multi-bit transition whose bits arrive slightly apart becomes one clean code change. Because of this, the window follows the new target during a dynamic voltage step.

The flag rises as soon as the output is back inside the window. An excursion outside the window only pulls the flag low after a long timeout, counted in microsecond ticks. A disabled output, the "off" code or a thermal shutdown pulls the flag low at once.

Top module: `pgood_supervisor`

## Requirements
- R1: The code is `vid_i` read as an unsigned binary number. Codes 0 to 30 select a target of 1100 mV + 25 mV × (30 − code), shown on `setpoint_mv_o`. Code 31 means off, and `setpoint_mv_o` shows 0. After reset the code is 31.
- R2: A new code takes effect only after its synchronized value has held for `STABLE_CYC` clock cycles (default 25, which is 500 ns at 50 MHz). A change that returns to the old code before then leaves `setpoint_mv_o` unchanged.
- R3: With the target at S mV, the window runs from S − floor(12·S/100) to S + floor(11·S/100), both limits included. With `en_i` high, a non-off code and no shutdown, `pgood_o` rises on the clock edge after `vfb_mv_i` enters the window.
- R4: After `vfb_mv_i` leaves the window, `pgood_o` stays high and falls on the clock edge that samples the `DELAY_US`-th (default 500) high `tick_us_i`.
- R5: If the voltage returns to the window before that tick, `pgood_o` never drops. The tick count restarts, so a later excursion again needs the full `DELAY_US` ticks.
- R6: `en_i` low forces `pgood_o` low on the next clock edge.
- R7: Code 31 forces `pgood_o` low on the clock edge after it takes effect.
- R8: `shdn_o` rises on the clock edge after `temp_c_i` (unsigned °C) is at or above `HOT_C` (default 150).
- R9: Once high, `shdn_o` stays high while `temp_c_i` is above `COOL_C` (default 125). It falls on the edge after `temp_c_i` is at or below `COOL_C`.
- R10: While `shdn_o` is high, `pgood_o` is forced low on the next clock edge.
- R11: During and right after reset, `pgood_o` and `shdn_o` are 0 and `setpoint_mv_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| en_i | input | 1 | Output enable, high to run |
| vid_i | input | 5 | Voltage-select code, asynchronous |
| vfb_mv_i | input | 12 | Sampled feedback voltage in mV |
| temp_c_i | input | 8 | Sampled die temperature in °C |
| pgood_o | output | 1 | Power good, high when the output is valid |
| shdn_o | output | 1 | Thermal shutdown request |
| setpoint_mv_o | output | 12 | Decoded target voltage in mV, 0 when off |

## Verification
A wrong code register shows up on `setpoint_mv_o` within one clock cycle of the stability period ending. A short glitch that leaks through the filter shows as a wrong target or a wrong flag. Both the window edges are probed exactly, so a wrong limit or rounding error shows as a flag that disagrees one edge after the voltage is applied. An excursion counter that starts at the wrong value, or fails to restart, moves the falling edge of the flag by at least one tick. The bench counts ticks itself to catch that. A hysteresis state that is lost shows as `shdn_o` releasing between the two thresholds.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned DEF_VID_W      = 5;
  localparam int unsigned DEF_MV_W       = 12;
  localparam int unsigned DEF_TEMP_W     = 8;
  localparam int unsigned DEF_STABLE_CYC = 25;
  localparam int unsigned DEF_DELAY_US   = 500;
  localparam int unsigned DEF_HOT_C      = 150;
  localparam int unsigned DEF_COOL_C     = 125;
  localparam int unsigned DEF_BASE_MV    = 1100;
  localparam int unsigned DEF_STEP_MV    = 25;
  localparam int unsigned DEF_HI_PCT     = 11;
  localparam int unsigned DEF_LO_PCT     = 12;

  // window edge: target scaled up or down by a whole percentage, truncated
  function automatic int scale_mv(input int sp, input int pct, input bit up);
    return up ? sp + (sp * pct) / 100 : sp - (sp * pct) / 100;
  endfunction
endpackage

// File: rtl/pg_vid_filter.sv
module pg_vid_filter #(
  parameter int unsigned VID_W      = pg_pkg::DEF_VID_W,
  parameter int unsigned MV_W       = pg_pkg::DEF_MV_W,
  parameter int unsigned STABLE_CYC = pg_pkg::DEF_STABLE_CYC,
  parameter int unsigned BASE_MV    = pg_pkg::DEF_BASE_MV,
  parameter int unsigned STEP_MV    = pg_pkg::DEF_STEP_MV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] vid_i,
  output logic             off_o,
  output logic [MV_W-1:0]  setpoint_o
);
  localparam int MAXC = (1 << VID_W) - 1;
  localparam int CW   = $clog2(STABLE_CYC + 1);

  logic [VID_W-1:0] sync1_q, sync2_q, cand_q, code_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '1;
      sync2_q <= '1;
      cand_q  <= '1;
      code_q  <= '1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= vid_i;
      sync2_q <= sync1_q;
      if (sync2_q != cand_q) begin
        cand_q <= sync2_q;
        cnt_q  <= '0;
      end else if (cnt_q != CW'(STABLE_CYC - 1)) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        code_q <= cand_q;
      end
    end
  end

  always_comb begin
    off_o = (code_q == '1);
    if (off_o) setpoint_o = '0;
    else setpoint_o = MV_W'(int'(BASE_MV) + int'(STEP_MV) * (MAXC - 1 - int'(code_q)));
  end
endmodule

// File: rtl/pg_window.sv
module pg_window #(
  parameter int unsigned MV_W   = pg_pkg::DEF_MV_W,
  parameter int unsigned HI_PCT = pg_pkg::DEF_HI_PCT,
  parameter int unsigned LO_PCT = pg_pkg::DEF_LO_PCT
) (
  input  logic [MV_W-1:0] setpoint_i,
  input  logic [MV_W-1:0] vfb_i,
  output logic            in_win_o
);
  int sp, hi, lo, v;
  always_comb begin
    sp = int'(setpoint_i);
    v  = int'(vfb_i);
    hi = pg_pkg::scale_mv(sp, int'(HI_PCT), 1'b1);
    lo = pg_pkg::scale_mv(sp, int'(LO_PCT), 1'b0);
    in_win_o = (sp != 0) && (v >= lo) && (v <= hi);
  end
endmodule

// File: rtl/pg_thermal.sv
module pg_thermal #(
  parameter int unsigned TEMP_W = pg_pkg::DEF_TEMP_W,
  parameter int unsigned HOT_C  = pg_pkg::DEF_HOT_C,
  parameter int unsigned COOL_C = pg_pkg::DEF_COOL_C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              shdn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shdn_o <= 1'b0;
    else if (temp_i >= TEMP_W'(HOT_C)) shdn_o <= 1'b1;
    else if (temp_i <= TEMP_W'(COOL_C)) shdn_o <= 1'b0;
  end
endmodule

// File: rtl/pg_delay.sv
module pg_delay #(
  parameter int unsigned DELAY_US = pg_pkg::DEF_DELAY_US
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic in_win_i,
  input  logic tick_i,
  output logic pg_o
);
  localparam int CW = (DELAY_US > 1) ? $clog2(DELAY_US) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_o  <= 1'b0;
      cnt_q <= '0;
    end else if (kill_i) begin
      pg_o  <= 1'b0;
      cnt_q <= '0;
    end else if (in_win_i) begin
      pg_o  <= 1'b1;
      cnt_q <= '0;
    end else if (pg_o && tick_i) begin
      if (cnt_q == CW'(DELAY_US - 1)) begin
        pg_o  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor #(
  parameter int unsigned VID_W      = pg_pkg::DEF_VID_W,
  parameter int unsigned MV_W       = pg_pkg::DEF_MV_W,
  parameter int unsigned TEMP_W     = pg_pkg::DEF_TEMP_W,
  parameter int unsigned STABLE_CYC = pg_pkg::DEF_STABLE_CYC,
  parameter int unsigned DELAY_US   = pg_pkg::DEF_DELAY_US,
  parameter int unsigned HOT_C      = pg_pkg::DEF_HOT_C,
  parameter int unsigned COOL_C     = pg_pkg::DEF_COOL_C,
  parameter int unsigned BASE_MV    = pg_pkg::DEF_BASE_MV,
  parameter int unsigned STEP_MV    = pg_pkg::DEF_STEP_MV,
  parameter int unsigned HI_PCT     = pg_pkg::DEF_HI_PCT,
  parameter int unsigned LO_PCT     = pg_pkg::DEF_LO_PCT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_us_i,
  input  logic              en_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [MV_W-1:0]   vfb_mv_i,
  input  logic [TEMP_W-1:0] temp_c_i,
  output logic              pgood_o,
  output logic              shdn_o,
  output logic [MV_W-1:0]   setpoint_mv_o
);
  logic off, in_win, kill;

  pg_vid_filter #(
    .VID_W(VID_W), .MV_W(MV_W), .STABLE_CYC(STABLE_CYC),
    .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
  ) vid_i_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .vid_i(vid_i),
    .off_o(off), .setpoint_o(setpoint_mv_o)
  );

  pg_window #(.MV_W(MV_W), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT)) win_i (
    .setpoint_i(setpoint_mv_o), .vfb_i(vfb_mv_i), .in_win_o(in_win)
  );

  pg_thermal #(.TEMP_W(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C)) therm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_c_i), .shdn_o(shdn_o)
  );

  // disable, off code and overtemperature bypass the excursion delay
  assign kill = !en_i || off || shdn_o;

  pg_delay #(.DELAY_US(DELAY_US)) dly_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill), .in_win_i(in_win),
    .tick_i(tick_us_i), .pg_o(pgood_o)
  );
endmodule

// File: rtl/pgood_supervisor_chk.sv
module pgood_supervisor_chk #(
  parameter int unsigned MV_W    = pg_pkg::DEF_MV_W,
  parameter int unsigned TEMP_W  = pg_pkg::DEF_TEMP_W,
  parameter int unsigned HOT_C   = pg_pkg::DEF_HOT_C,
  parameter int unsigned COOL_C  = pg_pkg::DEF_COOL_C,
  parameter int unsigned BASE_MV = pg_pkg::DEF_BASE_MV,
  parameter int unsigned STEP_MV = pg_pkg::DEF_STEP_MV,
  parameter int unsigned VID_W   = pg_pkg::DEF_VID_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_us_i,
  input logic              en_i,
  input logic [TEMP_W-1:0] temp_c_i,
  input logic              pgood_o,
  input logic              shdn_o,
  input logic [MV_W-1:0]   setpoint_mv_o
);
  localparam int TOP_MV = int'(BASE_MV) + int'(STEP_MV) * ((1 << VID_W) - 2);

  AST_SETPOINT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setpoint_mv_o == '0) || ((int'(setpoint_mv_o) >= int'(BASE_MV)) && (int'(setpoint_mv_o) <= TOP_MV))); // R1
  AST_PG_FALL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pgood_o) && $past(en_i) && !$past(shdn_o) && ($past(setpoint_mv_o) != '0)) |-> $past(tick_us_i)); // R4
  AST_PG_RISE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> ($past(en_i) && !$past(shdn_o) && ($past(setpoint_mv_o) != '0))); // R3
  AST_DIS_PG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pgood_o); // R6
  AST_OFF_PG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setpoint_mv_o == '0) |=> !pgood_o); // R7
  AST_HOT_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_c_i >= TEMP_W'(HOT_C)) |=> shdn_o); // R8
  AST_HYST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_o && (temp_c_i > TEMP_W'(COOL_C))) |=> shdn_o); // R9
  AST_HYST_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_o && (temp_c_i < TEMP_W'(HOT_C))) |=> !shdn_o); // R9
  AST_SHDN_PG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_o |=> !pgood_o); // R10
endmodule

bind pgood_supervisor pgood_supervisor_chk #(
  .MV_W(MV_W), .TEMP_W(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C),
  .BASE_MV(BASE_MV), .STEP_MV(STEP_MV), .VID_W(VID_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_us_i(tick_us_i), .en_i(en_i),
  .temp_c_i(temp_c_i), .pgood_o(pgood_o), .shdn_o(shdn_o),
  .setpoint_mv_o(setpoint_mv_o)
);

// File: tb/pgood_supervisor_tb_top.sv
`timescale 1ns/1ps
module pgood_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  vid = 5'd31;
  logic [11:0] vfb = '0;
  logic [7:0]  temp = 8'd25;
  logic        pgood, shdn;
  logic [11:0] sp;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgood_supervisor dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_us_i(tick), .en_i(en), .vid_i(vid),
    .vfb_mv_i(vfb), .temp_c_i(temp), .pgood_o(pgood), .shdn_o(shdn),
    .setpoint_mv_o(sp)
  );

  function automatic int sp_f(int code);
    return (code == 31) ? 0 : 1100 + 25 * (30 - code);
  endfunction

  function automatic int inwin_f(int code, int v);
    int s;
    s = sp_f(code);
    return (s != 0 && v >= s - (s * 12) / 100 && v <= s + (s * 11) / 100) ? 1 : 0;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(1);
    end
  endtask

  task automatic set_code(int code);
    vid = 5'(code); step(40);
  endtask

  // restart from a disabled state, then apply a voltage
  task automatic probe(int code, int v, string req);
    en = 1'b0; step(2);
    vfb = 12'(v); en = 1'b1; step(2);
    chk(req, int'(pgood), inwin_f(code, v));
  endtask

  task automatic finish_up();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk("R11 pgood in reset", int'(pgood), 0);
    chk("R11 shdn in reset", int'(shdn), 0);
    rst_ni = 1'b1; step(3);
    chk("R11 setpoint after reset", int'(sp), 0);
    chk("R11 pgood after reset", int'(pgood), 0);

    // R1 decode and R3 window edges at the lowest target
    set_code(30);
    chk("R1 code 30", int'(sp), 1100);
    probe(30, 968, "R3 low edge in");
    probe(30, 967, "R3 low edge out");
    probe(30, 1221, "R3 high edge in");
    probe(30, 1222, "R3 high edge out");
    set_code(0);
    chk("R1 code 0", int'(sp), 1850);
    probe(0, 1850 - 222, "R3 low edge code 0");
    probe(0, 1850 + 203, "R3 high edge code 0");
    probe(0, 1850 + 204, "R3 above high edge code 0");

    // R2 glitch filter
    set_code(10);
    vid = 5'd12; step(10); vid = 5'd10; step(40);
    chk("R2 short glitch ignored", int'(sp), sp_f(10));
    vid = 5'd12; step(20);
    chk("R2 not yet accepted", int'(sp), sp_f(10));
    step(20);
    chk("R2 accepted after stable", int'(sp), sp_f(12));

    // R4 and R5 excursion timing
    vfb = 12'(sp_f(12)); en = 1'b1; step(2);
    chk("R3 in window", int'(pgood), 1);
    vfb = 12'd500; step(2);
    ticks(300);
    chk("R5 still high mid delay", int'(pgood), 1);
    vfb = 12'(sp_f(12)); step(2);
    vfb = 12'd500; step(2);
    ticks(499);
    chk("R5 restart keeps high at 499", int'(pgood), 1);
    ticks(1);
    chk("R4 low at tick 500", int'(pgood), 0);
    vfb = 12'(sp_f(12)); step(2);
    chk("R3 immediate recovery", int'(pgood), 1);

    // R6 and R7
    en = 1'b0; step(1);
    chk("R6 disabled", int'(pgood), 0);
    en = 1'b1; step(1);
    chk("R3 re-enabled", int'(pgood), 1);
    vid = 5'd31; step(40);
    chk("R7 off code setpoint", int'(sp), 0);
    chk("R7 off code pgood", int'(pgood), 0);

    // R8 R9 R10 thermal
    set_code(20);
    vfb = 12'(sp_f(20)); step(2);
    chk("R3 before heat", int'(pgood), 1);
    temp = 8'd149; step(2);
    chk("R8 below trip", int'(shdn), 0);
    temp = 8'd150; step(1);
    chk("R8 trip", int'(shdn), 1);
    step(1);
    chk("R10 pgood forced low", int'(pgood), 0);
    temp = 8'd130; step(2);
    chk("R9 hold at 130", int'(shdn), 1);
    temp = 8'd126; step(2);
    chk("R9 hold at 126", int'(shdn), 1);
    chk("R10 still low", int'(pgood), 0);
    temp = 8'd125; step(1);
    chk("R9 release at 125", int'(shdn), 0);
    step(1);
    chk("R3 back after cool", int'(pgood), 1);
    temp = 8'd140; step(2);
    chk("R9 no retrip at 140", int'(shdn), 0);
    temp = 8'd25;

    // random codes and voltages
    for (int i = 0; i < 30; i++) begin
      int code, v, v2;
      code = int'($urandom_range(30, 0));
      set_code(code);
      chk("R1 random code", int'(sp), sp_f(code));
      v = int'($urandom_range(2300, 800));
      probe(code, v, "R3 random voltage");
      if (pgood) begin
        v2 = int'($urandom_range(2300, 0));
        vfb = 12'(v2); step(2);
        chk("R5 no drop without ticks", int'(pgood), 1);
      end
    end

    finish_up();
  end
endmodule